// File: doc/BRIEF.md
# Bus Ownership Mailbox Responder

This block is the device side of a small byte mailbox. The host reaches it through two I/O ports: an index port at 0x3E and a data port at 0x3F. A write to the index port picks a mailbox byte. Each later data access reads or writes the byte that was picked. Three bytes are implemented: a command byte at index 0x80, a response byte at index 0x82 and an argument byte at index 0x83.

Writing to the command byte while the mailbox is idle starts one command. The block then counts out a fixed delay that stands in for firmware latency. The only command it knows is 0x96 (bus ownership):

- Argument 0xB4 asks the local controller to leave the shared serial bus alone. The completion sets the `bus_yield` output.
- Argument 0xB5 hands the bus back. The completion clears `bus_yield`.

On completion the response byte receives 0xFA. Any other command or argument completes with 0xFF and leaves `bus_yield` as it was. The host clears the response byte, issues the command, then polls the response byte through the data port until it becomes nonzero.

Top module: `mbox_responder`

## Requirements
- R1: A write to I/O address 0x3E loads the mailbox index. A read of 0x3E returns the current index.
- R2: A read of 0x3E or 0x3F returns its data on `io_rdata` with `io_rvalid` high in the cycle after the read is sampled. Accesses to any other address produce no `io_rvalid` and change no state.
- R3: The argument byte (index 0x83) can be written and read back at any time.
- R4: While idle, the host can write the response byte (index 0x82) and read it back.
- R5: A data write to index 0x80 while idle starts a command. The response byte reads 0x00 from the next cycle until the command completes.
- R6: The response byte takes its completion code exactly LATENCY clocks after the clock edge that sampled the command write. Command 0x96 with argument 0xB4 or 0xB5 completes with 0xFA.
- R7: A completed 0x96/0xB4 command sets `bus_yield`, and a completed 0x96/0xB5 command clears it. `bus_yield` changes at no other time.
- R8: A command other than 0x96, or an argument other than 0xB4 or 0xB5, completes with 0xFF after the same delay and leaves `bus_yield` unchanged.
- R9: The command uses the argument held when it was started. An argument write during execution is stored but applies only to later commands.
- R10: While a command runs, writes to the command byte and to the response byte are ignored.
- R11: Index values other than 0x80, 0x82 and 0x83 read as 0x00, and writes to them are ignored.
- R12: After reset, `bus_yield`, `io_rvalid`, `io_rdata`, the index and all mailbox bytes are 0.
- R13: The command byte reads back the last command that was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | AW (16) | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| io_rvalid | output | 1 | High for one cycle when `io_rdata` carries a port read |
| bus_yield | output | 1 | High while the local controller must stay off the shared bus |

## Verification
The bench polls the response byte on every cycle around completion. A delay counter that is off by one moves the cycle in which the response goes from 0x00 to 0xFA, and the bench reports it. It also tries to restart a command and to overwrite the response while a command runs. A design that accepted either would end with 0xFF or the written value in place of 0xFA. It changes the argument during execution to catch a design that reads the live argument instead of the one held at start, and `bus_yield` would then flip the wrong way. Finally, it checks unknown indices, foreign I/O addresses and bad arguments, where a loose decoder would return stale data, corrupt the index or move `bus_yield`.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam logic [7:0] IDX_CMD   = 8'h80;
  localparam logic [7:0] IDX_RESP  = 8'h82;
  localparam logic [7:0] IDX_ARG   = 8'h83;
  localparam logic [7:0] OP_OWN    = 8'h96;
  localparam logic [7:0] ARG_TAKE  = 8'hB4;
  localparam logic [7:0] ARG_GIVE  = 8'hB5;
  localparam logic [7:0] RC_DONE   = 8'hFA;
  localparam logic [7:0] RC_ERR    = 8'hFF;

  typedef enum logic {EX_IDLE, EX_RUN} ex_state_t;

  typedef struct packed {
    logic       wr_idx;
    logic       wr_dat;
    logic       rd_idx;
    logic       rd_dat;
    logic [7:0] wdata;
  } host_op_t;
endpackage

// File: rtl/mbox_portdec.sv
module mbox_portdec
  import mbox_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] IDX_PORT = 'h3E
) (
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [7:0]    io_wdata,
  output host_op_t      op_o
);
  localparam logic [AW-1:0] DATA_PORT = IDX_PORT + AW'(1);

  logic hit_idx, hit_dat;

  always_comb begin
    hit_idx      = (io_addr == IDX_PORT);
    hit_dat      = (io_addr == DATA_PORT);
    op_o.wr_idx  = io_wr & hit_idx;
    op_o.wr_dat  = io_wr & hit_dat;
    op_o.rd_idx  = io_rd & hit_idx;
    op_o.rd_dat  = io_rd & hit_dat;
    op_o.wdata   = io_wdata;
  end
endmodule

// File: rtl/mbox_exec.sv
module mbox_exec
  import mbox_pkg::*;
#(
  parameter int LATENCY = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [7:0] cmd_i,
  input  logic [7:0] arg_i,
  output logic       busy_o,
  output logic       fin_o,
  output logic [7:0] code_o,
  output logic       yield_o
);
  localparam int CW = $clog2(LATENCY + 1);

  ex_state_t     state_q;
  logic [CW-1:0] cnt_q;
  logic          ok_q;
  logic          take_q;

  always_comb begin
    busy_o = (state_q == EX_RUN);
    fin_o  = busy_o && (cnt_q == '0);
    code_o = ok_q ? RC_DONE : RC_ERR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= EX_IDLE;
      cnt_q   <= '0;
      ok_q    <= 1'b0;
      take_q  <= 1'b0;
      yield_o <= 1'b0;
    end else begin
      case (state_q)
        EX_IDLE: begin
          if (start_i) begin
            state_q <= EX_RUN;
            cnt_q   <= CW'(LATENCY - 1);
            ok_q    <= (cmd_i == OP_OWN) &&
                       ((arg_i == ARG_TAKE) || (arg_i == ARG_GIVE));
            take_q  <= (arg_i == ARG_TAKE);
          end
        end
        default: begin
          if (cnt_q == '0) begin
            state_q <= EX_IDLE;
            if (ok_q) yield_o <= take_q;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mbox_bytes.sv
module mbox_bytes
  import mbox_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  host_op_t   op_i,
  input  logic       busy_i,
  input  logic       fin_i,
  input  logic [7:0] code_i,
  output logic       start_o,
  output logic [7:0] arg_o,
  output logic [7:0] rdata_o,
  output logic       rvalid_o
);
  logic [7:0] index_q, cmd_q, resp_q, arg_q;
  logic [7:0] sel_byte;

  always_comb begin
    start_o = op_i.wr_dat && (index_q == IDX_CMD) && !busy_i;
    arg_o   = arg_q;
    case (index_q)
      IDX_CMD:  sel_byte = cmd_q;
      IDX_RESP: sel_byte = resp_q;
      IDX_ARG:  sel_byte = arg_q;
      default:  sel_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q  <= '0;
      cmd_q    <= '0;
      resp_q   <= '0;
      arg_q    <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      if (op_i.wr_idx) index_q <= op_i.wdata;
      if (start_o) cmd_q <= op_i.wdata;
      if (op_i.wr_dat && index_q == IDX_ARG) arg_q <= op_i.wdata;
      if (fin_i)
        resp_q <= code_i;
      else if (start_o)
        resp_q <= 8'h00;
      else if (op_i.wr_dat && index_q == IDX_RESP && !busy_i)
        resp_q <= op_i.wdata;
      rvalid_o <= op_i.rd_idx | op_i.rd_dat;
      if (op_i.rd_idx)      rdata_o <= index_q;
      else if (op_i.rd_dat) rdata_o <= sel_byte;
      else                  rdata_o <= 8'h00;
    end
  end
endmodule

// File: rtl/mbox_responder.sv
module mbox_responder
  import mbox_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] IDX_PORT = 'h3E,
  parameter int LATENCY = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  output logic          io_rvalid,
  output logic          bus_yield
);
  host_op_t   op_w;
  logic       start_w, busy_w, fin_w;
  logic [7:0] code_w, arg_w;

  mbox_portdec #(.AW(AW), .IDX_PORT(IDX_PORT)) u_dec (
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .op_o(op_w)
  );

  mbox_bytes u_bytes (
    .clk(clk), .rst(rst), .op_i(op_w), .busy_i(busy_w), .fin_i(fin_w),
    .code_i(code_w), .start_o(start_w), .arg_o(arg_w),
    .rdata_o(io_rdata), .rvalid_o(io_rvalid)
  );

  mbox_exec #(.LATENCY(LATENCY)) u_exec (
    .clk(clk), .rst(rst), .start_i(start_w), .cmd_i(op_w.wdata),
    .arg_i(arg_w), .busy_o(busy_w), .fin_o(fin_w), .code_o(code_w),
    .yield_o(bus_yield)
  );
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int AW = 16,
  parameter logic [AW-1:0] IDX_PORT = 'h3E,
  parameter int LATENCY = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] io_addr,
  input logic          io_rd,
  input logic          io_rvalid,
  input logic          bus_yield,
  input logic          start,
  input logic          busy,
  input logic          fin
);
  localparam int LW = $clog2(LATENCY + 2) + 1;
  logic [LW-1:0] lat_cnt;
  logic          port_rd;

  assign port_rd = io_rd && ((io_addr == IDX_PORT) || (io_addr == IDX_PORT + AW'(1)));

  always_ff @(posedge clk) begin
    if (rst)        lat_cnt <= '0;
    else if (start) lat_cnt <= LW'(1);
    else if (busy)  lat_cnt <= lat_cnt + LW'(1);
  end

  // R6: completion lands exactly LATENCY clocks after the start edge
  a_r6_latency: assert property (@(posedge clk) disable iff (rst)
    fin |-> (lat_cnt == LW'(LATENCY)));
  // R5: a start puts the engine into its running state
  a_r5_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  // R10: no new start is accepted while running
  a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);
  // R7: the yield output moves only on a completion
  a_r7_yield_on_fin: assert property (@(posedge clk) disable iff (rst)
    !fin |=> $stable(bus_yield));
  // R2: port reads answer next cycle, nothing else does
  a_r2_rvalid: assert property (@(posedge clk) disable iff (rst)
    port_rd |=> io_rvalid);
  a_r2_no_stray: assert property (@(posedge clk) disable iff (rst)
    !port_rd |=> !io_rvalid);
endmodule

bind mbox_responder mbox_checker #(.AW(AW), .IDX_PORT(IDX_PORT), .LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_rvalid(io_rvalid),
  .bus_yield(bus_yield), .start(start_w), .busy(busy_w), .fin(fin_w)
);

// File: tb/tb_mbox_responder.sv
module tb_mbox_responder;
  localparam int LAT = 8;
  localparam logic [15:0] PI = 16'h003E;
  localparam logic [15:0] PD = 16'h003F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rvalid, bus_yield;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  mbox_responder #(.LATENCY(LAT)) dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .bus_yield(bus_yield)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per returned read
  always @(negedge clk) begin
    if (!rst && io_rvalid) begin
      if (exp_q.size() == 0) check(1'b0, "R2 stray rvalid", 1, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(io_rdata == e, t, io_rdata, e);
      end
    end
  end

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, input logic [7:0] e, input string t);
    if (a == PI || a == PD) begin exp_q.push_back(e); tag_q.push_back(t); end
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic mb_write(input logic [7:0] idx, input logic [7:0] v);
    io_write(PI, idx); io_write(PD, v);
  endtask

  task automatic mb_read(input logic [7:0] idx, input logic [7:0] e, input string t);
    io_write(PI, idx); io_read(PD, e, t);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // start a command and poll the response on every cycle around completion
  task automatic timed_cmd(input logic [7:0] cmd, input logic [7:0] argv,
                           input logic [7:0] code, input logic y_new);
    logic y_old;
    mb_write(8'h83, argv);
    mb_write(8'h82, 8'h00);
    y_old = bus_yield;
    io_write(PI, 8'h80);
    io_write(PD, cmd);          // start edge E0
    io_write(PI, 8'h82);        // edge E0+1
    for (int k = 2; k <= LAT + 1; k++) begin
      io_read(PD, (k <= LAT) ? 8'h00 : code, "R5/R6/R8 response timing");
      check(bus_yield == ((k >= LAT) ? y_new : y_old), "R7/R8 yield timing",
            bus_yield, (k >= LAT) ? y_new : y_old);
    end
  endtask

  task automatic finish_run();
    idle(3);
    check(exp_q.size() == 0, "R2 missing read data", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    check(bus_yield == 1'b0, "R12 yield after reset", bus_yield, 0);
    check(io_rvalid == 1'b0, "R12 rvalid after reset", io_rvalid, 0);
    check(io_rdata == 8'h00, "R12 rdata after reset", io_rdata, 0);
    io_read(PI, 8'h00, "R12 index after reset");
    io_read(PD, 8'h00, "R12 byte at index 0");
    mb_read(8'h80, 8'h00, "R12 command after reset");
    mb_read(8'h82, 8'h00, "R12 response after reset");
    mb_read(8'h83, 8'h00, "R12 argument after reset");
    // R1 index readback
    io_write(PI, 8'h5A);
    io_read(PI, 8'h5A, "R1 index readback");
    // R2 foreign address: no rvalid, no index change
    io_read(16'h0040, 8'h00, "R2 foreign read");
    io_write(16'h003D, 8'h83);
    io_write(16'h0140, 8'h11);
    io_read(PI, 8'h5A, "R2 foreign write left index");
    // R3 argument, R4 response while idle
    mb_write(8'h83, 8'h3C);
    mb_read(8'h83, 8'h3C, "R3 argument readback");
    mb_write(8'h82, 8'h33);
    mb_read(8'h82, 8'h33, "R4 response readback");
    // R11 unmapped indices
    mb_write(8'h81, 8'hAA);
    mb_read(8'h81, 8'h00, "R11 unmapped 0x81");
    mb_write(8'h84, 8'hAB);
    mb_read(8'h84, 8'h00, "R11 unmapped 0x84");
    mb_read(8'hFF, 8'h00, "R11 unmapped 0xFF");
    mb_read(8'h83, 8'h3C, "R11 argument untouched");
    // R6/R7 take and give
    timed_cmd(8'h96, 8'hB4, 8'hFA, 1'b1);
    mb_read(8'h80, 8'h96, "R13 command readback");
    timed_cmd(8'h96, 8'hB5, 8'hFA, 1'b0);
    timed_cmd(8'h96, 8'hB4, 8'hFA, 1'b1);
    // R8 bad argument and unknown command keep yield
    timed_cmd(8'h96, 8'h12, 8'hFF, 1'b1);
    timed_cmd(8'h55, 8'hB5, 8'hFF, 1'b1);
    mb_read(8'h80, 8'h55, "R13 unknown command readback");
    // R10 writes during execution ignored
    mb_write(8'h83, 8'hB5);
    mb_write(8'h80, 8'h96);
    mb_write(8'h82, 8'h77);
    mb_write(8'h80, 8'h55);
    idle(LAT + 2);
    mb_read(8'h82, 8'hFA, "R10 response write while busy ignored");
    mb_read(8'h80, 8'h96, "R10 command write while busy ignored");
    check(bus_yield == 1'b0, "R7 give completed", bus_yield, 0);
    idle(LAT + 2);
    mb_read(8'h82, 8'hFA, "R10 no second command");
    // R9 argument held at start
    mb_write(8'h83, 8'hB4);
    mb_write(8'h80, 8'h96);
    mb_write(8'h83, 8'hB5);
    idle(LAT + 2);
    check(bus_yield == 1'b1, "R9 captured argument used", bus_yield, 1);
    mb_read(8'h83, 8'hB5, "R9 argument write stored");
    mb_read(8'h82, 8'hFA, "R9 completion code");
    finish_run();
  end
endmodule